// File: doc/BRIEF.md
# Monitoring Engine Allocator

This block hands out a fixed pool of performance-monitoring engines to connections on demand. A requester presents one request per cycle on a request channel. The request is either an activation or a deactivation, and it carries a connection identifier. On the next cycle the block answers on a response channel with a confirm or a deny and an engine index.

An activation binds the lowest-numbered free engine to the connection and returns that engine's index. If the connection already holds an engine, the existing index comes back and no second engine is taken. When every engine is busy, a new activation is denied. A deactivation releases the engine bound to the connection and is always confirmed, even when no engine was bound to it.

The block is used by the port that originates forward monitoring cells. The result of each handshake decides whether a monitoring session can start.

Top module: `mon_alloc`

## Requirements
- R1: The pool holds NUM_ENG = 128 engines by default, numbered 0 to 127 and reported on a 7-bit `rsp_idx`.
- R2: Every cycle with `req_valid` high yields exactly one cycle with `rsp_valid` high, on the following cycle. `rsp_valid` is low after reset and on every cycle that follows a cycle without a request.
- R3: An activation (`req_kind` = 0) for an unbound connection, while any engine is free, returns confirm (`rsp_kind` = 0) with the lowest free engine index and binds that engine.
- R4: An activation for an unbound connection while all engines are bound returns deny (`rsp_kind` = 1) with `rsp_idx` = 0 and changes no binding.
- R5: An activation for a connection that already holds an engine returns confirm with that engine's index, even when the pool is full, and binds no further engine.
- R6: A deactivation (`req_kind` = 1) for a bound connection returns confirm with the released index, and that engine becomes available to later activations.
- R7: A deactivation for a connection with no bound engine returns confirm with `rsp_idx` = 0 and changes no binding.
- R8: A request accepted on the cycle right after another request sees the bindings as updated by that earlier request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; frees all engines |
| req_valid | input | 1 | A request is presented this cycle |
| req_kind | input | 1 | 0 = activate, 1 = deactivate |
| req_cid | input | CID_W | Connection identifier of the request |
| rsp_valid | output | 1 | Response is valid |
| rsp_kind | output | 1 | 0 = confirm, 1 = deny |
| rsp_idx | output | IDX_W | Engine index (0 on deny or on an unbound deactivation) |

## Verification
An activation runs the connection lookup and the free-engine search in the same cycle, and the lookup must win. The bench provokes this by repeating an activation for a bound connection while the pool is full. The existing index must come back rather than a deny, and a following new activation must still be denied, which shows that no engine was taken. A release and a new allocation also meet across consecutive cycles. The bench issues a deactivation immediately followed by an activation and expects the just-freed index.

// File: rtl/mon_alloc_pkg.sv
package mon_alloc_pkg;
  typedef enum logic {REQ_ACT = 1'b0, REQ_DEACT = 1'b1} req_kind_e;
  typedef enum logic {RSP_CONFIRM = 1'b0, RSP_DENY = 1'b1} rsp_kind_e;
endpackage

// File: rtl/mon_free_finder.sv
module mon_free_finder #(
  parameter int NUM_ENG = 128,
  localparam int IDX_W = $clog2(NUM_ENG)
) (
  input  logic [NUM_ENG-1:0] busy,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  // lowest index wins: scan from the top so the last hit is the smallest
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_ENG - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (found) p_pick_free_r3: assert (!busy[idx]);
    else       p_none_free_r4: assert (&busy);
  end
endmodule

// File: rtl/mon_bind_table.sv
module mon_bind_table #(
  parameter int NUM_ENG = 128,
  parameter int CID_W   = 16,
  localparam int IDX_W  = $clog2(NUM_ENG)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_en,
  input  logic [IDX_W-1:0]   set_idx,
  input  logic [CID_W-1:0]   set_cid,
  input  logic               clr_en,
  input  logic [IDX_W-1:0]   clr_idx,
  input  logic [CID_W-1:0]   look_cid,
  output logic [NUM_ENG-1:0] busy,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx
);
  logic [CID_W-1:0]   cid_tab [NUM_ENG];
  logic [NUM_ENG-1:0] match;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= '0;
    end else begin
      if (set_en) busy[set_idx] <= 1'b1;
      if (clr_en) busy[clr_idx] <= 1'b0;
    end
  end

  // identifier store: single write port, no reset
  always_ff @(posedge clk) begin
    if (set_en) cid_tab[set_idx] <= set_cid;
  end

  for (genvar g = 0; g < NUM_ENG; g++) begin : g_cmp
    assign match[g] = busy[g] && (cid_tab[g] == look_cid);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NUM_ENG; i++) begin
      if (match[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end
  assign hit = |match;

  p_single_bind_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));
  p_set_only_free_r3: assert property (@(posedge clk) disable iff (rst)
    set_en |-> !busy[set_idx]);
  p_clr_only_busy_r6: assert property (@(posedge clk) disable iff (rst)
    clr_en |-> busy[clr_idx]);
  p_step_one_r8: assert property (@(posedge clk) disable iff (rst)
    !(set_en && clr_en));
endmodule

// File: rtl/mon_alloc.sv
module mon_alloc
  import mon_alloc_pkg::*;
#(
  parameter int NUM_ENG = 128,
  parameter int CID_W   = 16,
  localparam int IDX_W  = $clog2(NUM_ENG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_kind,
  input  logic [CID_W-1:0] req_cid,
  output logic             rsp_valid,
  output logic             rsp_kind,
  output logic [IDX_W-1:0] rsp_idx
);
  logic [NUM_ENG-1:0] busy;
  logic               hit, free_found;
  logic [IDX_W-1:0]   hit_idx, free_idx;
  logic               is_act, is_deact, do_alloc, do_release, deny;

  assign is_act     = req_valid && (req_kind == REQ_ACT);
  assign is_deact   = req_valid && (req_kind == REQ_DEACT);
  assign do_alloc   = is_act && !hit && free_found;
  assign do_release = is_deact && hit;
  assign deny       = is_act && !hit && !free_found;

  mon_free_finder #(.NUM_ENG(NUM_ENG)) u_find (
    .busy  (busy),
    .found (free_found),
    .idx   (free_idx)
  );

  mon_bind_table #(.NUM_ENG(NUM_ENG), .CID_W(CID_W)) u_tab (
    .clk      (clk),
    .rst      (rst),
    .set_en   (do_alloc),
    .set_idx  (free_idx),
    .set_cid  (req_cid),
    .clr_en   (do_release),
    .clr_idx  (hit_idx),
    .look_cid (req_cid),
    .busy     (busy),
    .hit      (hit),
    .hit_idx  (hit_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_kind  <= RSP_CONFIRM;
      rsp_idx   <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_kind  <= deny ? RSP_DENY : RSP_CONFIRM;
      if (req_valid && hit)        rsp_idx <= hit_idx;
      else if (is_act && !deny)    rsp_idx <= free_idx;
      else                         rsp_idx <= '0;
    end
  end

  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  p_deact_confirm_r7: assert property (@(posedge clk) disable iff (rst)
    is_deact |=> (rsp_kind == RSP_CONFIRM));
  p_deny_only_full_r4: assert property (@(posedge clk) disable iff (rst)
    (is_act && !(&busy)) |=> (rsp_kind == RSP_CONFIRM));
  p_bound_confirm_r5: assert property (@(posedge clk) disable iff (rst)
    (is_act && hit) |=> (rsp_kind == RSP_CONFIRM));
  p_deny_keeps_state_r4: assert property (@(posedge clk) disable iff (rst)
    deny |=> $stable(busy));
endmodule

// File: tb/tb_mon_alloc.sv
module tb_mon_alloc;
  localparam int NUM_ENG = 128;
  localparam int CID_W   = 16;
  localparam int IDX_W   = $clog2(NUM_ENG);
  localparam int BASE    = 100;
  localparam logic ACT = 1'b0, DEACT = 1'b1, CONF = 1'b0, DENY = 1'b1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_kind  = 1'b0;
  logic [CID_W-1:0] req_cid = '0;
  logic rsp_valid, rsp_kind;
  logic [IDX_W-1:0] rsp_idx;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  mon_alloc #(.NUM_ENG(NUM_ENG), .CID_W(CID_W)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_cid(req_cid), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
    .rsp_idx(rsp_idx)
  );

  always #5 clk = ~clk;

  task automatic chk_now(input logic ek, input int eidx, input string tag);
    checks++;
    if (!(rsp_valid === 1'b1 && rsp_kind === ek && int'(rsp_idx) == eidx)) begin
      errors++;
      $display("FAIL %s: got v=%b kind=%b idx=%0d, expected v=1 kind=%b idx=%0d",
               tag, rsp_valid, rsp_kind, rsp_idx, ek, eidx);
    end
  endtask

  task automatic send(input logic k, input int cid);
    @(negedge clk);
    req_valid = 1'b1;
    req_kind  = k;
    req_cid   = CID_W'(cid);
  endtask

  task automatic expect_rsp(input logic ek, input int eidx, input string tag);
    @(negedge clk);
    chk_now(ek, eidx, tag);
    req_valid = 1'b0;
  endtask

  task automatic req(input logic k, input int cid, input logic ek, input int eidx,
                     input string tag);
    send(k, cid);
    expect_rsp(ek, eidx, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got running, expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_idx !== '0) begin
      errors++;
      $display("FAIL R2 reset: got v=%b idx=%0d, expected v=0 idx=0", rsp_valid, rsp_idx);
    end

    // R1/R3: fill the pool in order
    for (int i = 0; i < NUM_ENG; i++) req(ACT, BASE + i, CONF, i, "R3 fill");
    checks++;
    if ($bits(rsp_idx) != 7) begin
      errors++;
      $display("FAIL R1: got idx width %0d, expected 7", $bits(rsp_idx));
    end

    // R2: idle cycle gives no response
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R2 idle: got v=%b, expected v=0", rsp_valid);
    end

    req(ACT, 5000, DENY, 0, "R4 full");
    req(ACT, BASE + 77, CONF, 77, "R5 bound while full");
    req(ACT, 5001, DENY, 0, "R5 no second engine");
    req(DEACT, 4000, CONF, 0, "R7 unbound release");
    req(ACT, 5002, DENY, 0, "R7 state unchanged");

    // R6: release every third engine
    for (int i = 0; i < NUM_ENG; i += 3) req(DEACT, BASE + i, CONF, i, "R6 release");
    // R3/R6: refill lowest first
    for (int k = 0; 3 * k < NUM_ENG; k++) req(ACT, 6000 + k, CONF, 3 * k, "R6 reuse");
    req(ACT, 5003, DENY, 0, "R4 full again");
    req(DEACT, BASE, CONF, 0, "R7 old cid unbound");
    req(ACT, 6000, CONF, 0, "R5 new cid bound");

    // R8: back-to-back release then activation
    send(DEACT, BASE + 1);
    @(negedge clk);
    chk_now(CONF, 1, "R8 release");
    req_kind = ACT;
    req_cid  = CID_W'(7000);
    expect_rsp(CONF, 1, "R8 reuse next cycle");
    req(ACT, 7001, DENY, 0, "R8 full after reuse");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule